// File: doc/BRIEF.md
# DMA Channel Register File with Set/Clear Aliases

This block is the software-visible register slave of one DMA channel. A host reaches it through a simple valid/ready port with a word address and 32-bit data. It holds the channel's control word and interrupt-enable mask. Both can be written whole, or changed bit by bit through a set alias and a clear alias, so software never needs a read-modify-write. It also exposes a read-only identifier. The identifier's signature lets software find out whether the channel exists and which direction it moves data.

The channel engine reports events to this block as one-cycle pulses. An event is caught in a sticky status bit only when its enable bit in the control word is set. A status read returns the caught bits and clears them. The interrupt request is raised while any caught bit is also enabled in the interrupt-enable mask. The block also counts completed descriptors while the channel runs. It drives the run bit and the two addressing/writeback mode bits to the engine.

Top module: `dma_chan_regs`

## Requirements
- R1: A read of byte offset 0x00 returns 0x1FC0 plus DIR in bits 31:16 and zero in bits 15:0, where DIR is 0 for host-to-card and 1 for card-to-host.
- R2: A write to offset 0x04 loads the control word with the written data ANDed with the writable mask 0x06F83E5F. Bit 0 is run, bits 1, 2, 3, 4 and 6 and bit groups 13:9 and 23:19 are event enables, bit 25 is non-incrementing address and bit 26 is poll-mode writeback. Every other bit reads zero.
- R3: A write to offset 0x08 sets the control bits written as one. A write to offset 0x0C clears the control bits written as one. Bits written as zero keep their value in both cases. Reading either alias returns the control word.
- R4: The interrupt-enable mask is at offset 0x90, with a set alias at 0x94 and a clear alias at 0x9C. It behaves like R2 and R3, but its writable mask is 0x00F83E5E.
- R5: run_o, non_incr_o and poll_wb_o show control bits 0, 25 and 26 from the clock edge that accepts the write.
- R6: A pulse on evt_i bit n sets status bit n only if n lies in the event mask 0x00F83E5E and control bit n is set. Status bits stay set until status is read. Other bits of evt_i have no effect.
- R7: A read of offset 0x40 returns the status and clears it at the same edge. An event caught at that same edge stays set for the next read.
- R8: irq_o is high exactly when some status bit is set whose interrupt-enable bit is also set.
- R9: The count at offset 0x48 rises by one on each cycle with desc_done_i high while run is set. It is cleared at the edge where run goes from 0 to 1.
- R10: A read of offset 0x4C returns align_i as sampled at the accepting edge.
- R11: Reads of offsets not listed in R1 to R10 return zero. Writes to those offsets, and to offsets 0x00, 0x40, 0x48 and 0x4C, change no state.
- R12: req_ready_o is always high. rsp_valid_o pulses for one cycle after each accepted read and stays low after writes.
- R13: After reset, control, interrupt enable, status and count are zero, and irq_o, run_o and rsp_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready, always high |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | ADDR_W | Word address (byte offset divided by 4) |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata_o | output | 32 | Read data |
| evt_i | input | 32 | Event pulses from the engine, by status bit position |
| desc_done_i | input | 1 | Descriptor completed pulse |
| align_i | input | 32 | Alignment information from the engine |
| run_o | output | 1 | Run bit |
| non_incr_o | output | 1 | Non-incrementing address mode |
| poll_wb_o | output | 1 | Poll-mode writeback |
| irq_o | output | 1 | Interrupt request |

## Verification
Most wrong internal state reaches a port right after the edge that caused it. A bad control bit shows on run_o or the mode outputs at once. A lost or spurious status bit changes irq_o in the same cycle, provided its interrupt enable is set. The fault is also visible in the next status read. A slip in the count or in clear-on-read stays hidden until software reads 0x48 or 0x40. For that reason the stimulus reads those offsets often, interleaved with events, completions and run toggles.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;

  localparam int unsigned DATA_W = 32;

  // writable bits of control and of the interrupt-enable mask
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h06F8_3E5F;
  localparam logic [DATA_W-1:0] EVT_MASK  = 32'h00F8_3E5E;

  localparam int unsigned RUN_BIT      = 0;
  localparam int unsigned NON_INCR_BIT = 25;
  localparam int unsigned POLL_WB_BIT  = 26;

  localparam logic [15:0] SIG_BASE = 16'h1FC0;

  // word offsets (byte offset / 4)
  localparam int unsigned W_ID       = 0;
  localparam int unsigned W_CTRL     = 1;
  localparam int unsigned W_CTRL_SET = 2;
  localparam int unsigned W_CTRL_CLR = 3;
  localparam int unsigned W_STAT     = 16;
  localparam int unsigned W_DONE     = 18;
  localparam int unsigned W_ALIGN    = 19;
  localparam int unsigned W_IE       = 36;
  localparam int unsigned W_IE_SET   = 37;
  localparam int unsigned W_IE_CLR   = 39;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_CTRL,
    SEL_STAT,
    SEL_DONE,
    SEL_ALIGN,
    SEL_IE
  } reg_sel_e;

  typedef enum logic [1:0] {
    WR_PLAIN,
    WR_SET,
    WR_CLR
  } wr_op_e;

  typedef struct packed {
    reg_sel_e sel;
    wr_op_e   op;
  } dec_t;

endpackage

// File: rtl/dma_chan_addr_dec.sv
module dma_chan_addr_dec
  import dma_chan_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);

  always_comb begin
    dec_o.sel = SEL_NONE;
    dec_o.op  = WR_PLAIN;
    if (addr_i == ADDR_W'(W_ID)) begin
      dec_o.sel = SEL_ID;
    end else if (addr_i == ADDR_W'(W_CTRL)) begin
      dec_o.sel = SEL_CTRL;
    end else if (addr_i == ADDR_W'(W_CTRL_SET)) begin
      dec_o.sel = SEL_CTRL;
      dec_o.op  = WR_SET;
    end else if (addr_i == ADDR_W'(W_CTRL_CLR)) begin
      dec_o.sel = SEL_CTRL;
      dec_o.op  = WR_CLR;
    end else if (addr_i == ADDR_W'(W_STAT)) begin
      dec_o.sel = SEL_STAT;
    end else if (addr_i == ADDR_W'(W_DONE)) begin
      dec_o.sel = SEL_DONE;
    end else if (addr_i == ADDR_W'(W_ALIGN)) begin
      dec_o.sel = SEL_ALIGN;
    end else if (addr_i == ADDR_W'(W_IE)) begin
      dec_o.sel = SEL_IE;
    end else if (addr_i == ADDR_W'(W_IE_SET)) begin
      dec_o.sel = SEL_IE;
      dec_o.op  = WR_SET;
    end else if (addr_i == ADDR_W'(W_IE_CLR)) begin
      dec_o.sel = SEL_IE;
      dec_o.op  = WR_CLR;
    end
  end

endmodule

// File: rtl/dma_chan_alias_reg.sv
module dma_chan_alias_reg
  import dma_chan_regs_pkg::*;
#(
  parameter int unsigned      W    = 32,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  wr_op_e       op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] d_o
);

  logic [W-1:0] q;
  logic [W-1:0] d;
  logic [W-1:0] wmask;

  assign wmask = wdata_i & MASK;

  always_comb begin
    d = q;
    if (we_i) begin
      unique case (op_i)
        WR_SET:  d = q | wmask;
        WR_CLR:  d = q & ~wmask;
        default: d = wmask;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign q_o = q;
  assign d_o = d;

endmodule

// File: rtl/dma_chan_evt_status.sv
module dma_chan_evt_status #(
  parameter int unsigned  W        = 32,
  parameter logic [W-1:0] EVT_BITS = '1,
  parameter int unsigned  CNT_W    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     evt_i,
  input  logic [W-1:0]     en_i,
  input  logic             rd_clr_i,
  input  logic             run_q_i,
  input  logic             run_d_i,
  input  logic             done_i,
  output logic [W-1:0]     stat_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [W-1:0]     stat_q;
  logic [W-1:0]     stat_d;
  logic [CNT_W-1:0] cnt_q;
  logic             run_rise;

  // only event positions get a sticky bit; new events win over a read-clear
  for (genvar i = 0; i < W; i++) begin : g_stat
    if (EVT_BITS[i]) begin : g_evt
      assign stat_d[i] = (stat_q[i] & ~rd_clr_i) | (evt_i[i] & en_i[i]);
    end else begin : g_rsvd
      assign stat_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign run_rise = run_d_i & ~run_q_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (run_rise)           cnt_q <= '0;
    else if (done_i && run_q_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign stat_o = stat_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_regs_pkg::*;
#(
  parameter bit          DIR    = 1'b0,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  input  logic [31:0]       evt_i,
  input  logic              desc_done_i,
  input  logic [31:0]       align_i,
  output logic              run_o,
  output logic              non_incr_o,
  output logic              poll_wb_o,
  output logic              irq_o
);

  localparam logic [DATA_W-1:0] ID_WORD = {SIG_BASE + 16'(DIR), 16'h0000};

  dec_t              dec;
  logic              accept;
  logic              wr_acc;
  logic              rd_acc;
  logic              ctrl_we;
  logic              ie_we;
  logic              rd_clr;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ctrl_d;
  logic [DATA_W-1:0] ie_q;
  logic [DATA_W-1:0] ie_d;
  logic [DATA_W-1:0] stat_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rdata_d;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  assign req_ready_o = 1'b1;
  assign accept      = req_valid_i & req_ready_o;
  assign wr_acc      = accept & req_write_i;
  assign rd_acc      = accept & ~req_write_i;

  dma_chan_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (req_addr_i),
    .dec_o  (dec)
  );

  assign ctrl_we = wr_acc & (dec.sel == SEL_CTRL);
  assign ie_we   = wr_acc & (dec.sel == SEL_IE);
  assign rd_clr  = rd_acc & (dec.sel == SEL_STAT);

  dma_chan_alias_reg #(.W(DATA_W), .MASK(CTRL_MASK)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .op_i    (dec.op),
    .wdata_i (req_wdata_i),
    .q_o     (ctrl_q),
    .d_o     (ctrl_d)
  );

  dma_chan_alias_reg #(.W(DATA_W), .MASK(EVT_MASK)) u_ie (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ie_we),
    .op_i    (dec.op),
    .wdata_i (req_wdata_i),
    .q_o     (ie_q),
    .d_o     (ie_d)
  );

  dma_chan_evt_status #(.W(DATA_W), .EVT_BITS(EVT_MASK), .CNT_W(CNT_W)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .en_i     (ctrl_q),
    .rd_clr_i (rd_clr),
    .run_q_i  (ctrl_q[RUN_BIT]),
    .run_d_i  (ctrl_d[RUN_BIT]),
    .done_i   (desc_done_i),
    .stat_o   (stat_q),
    .cnt_o    (cnt_q)
  );

  always_comb begin
    unique case (dec.sel)
      SEL_ID:    rdata_d = ID_WORD;
      SEL_CTRL:  rdata_d = ctrl_q;
      SEL_STAT:  rdata_d = stat_q;
      SEL_DONE:  rdata_d = DATA_W'(cnt_q);
      SEL_ALIGN: rdata_d = align_i;
      SEL_IE:    rdata_d = ie_q;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_acc;
      if (rd_acc) rsp_rdata_q <= rdata_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign run_o       = ctrl_q[RUN_BIT];
  assign non_incr_o  = ctrl_q[NON_INCR_BIT];
  assign poll_wb_o   = ctrl_q[POLL_WB_BIT];
  assign irq_o       = |(stat_q & ie_q);

  logic unused_ie_d;
  assign unused_ie_d = ^ie_d;

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_chan_regs_pkg::*;
#(
  parameter bit          DIR    = 1'b0,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [31:0]       req_wdata_i,
  input logic              rsp_valid_o,
  input logic [31:0]       rsp_rdata_o,
  input logic              irq_o,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       ie_q,
  input logic [31:0]       stat_q
);

  logic rd_stat;
  assign rd_stat = req_valid_i && !req_write_i && (req_addr_i == ADDR_W'(W_STAT));

  // R1
  a_r1_signature: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i == ADDR_W'(W_ID))
    |=> (rsp_rdata_o[31:16] == SIG_BASE + 16'(DIR)));

  // R3
  a_r3_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_addr_i == ADDR_W'(W_CTRL_SET))
    |=> ((ctrl_q & ($past(req_wdata_i) & CTRL_MASK)) == ($past(req_wdata_i) & CTRL_MASK)));

  a_r3_clr_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_addr_i == ADDR_W'(W_CTRL_CLR))
    |=> ((ctrl_q & $past(req_wdata_i)) == 32'h0));

  // R6
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R8
  a_r8_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((ie_q != 32'h0) && (stat_q != 32'h0)));

  // R12
  a_r12_read_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);

  a_r12_write_no_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> !rsp_valid_o);

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DIR(DIR), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .irq_o       (irq_o),
  .ctrl_q      (ctrl_q),
  .ie_q        (ie_q),
  .stat_q      (stat_q)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;

  localparam bit          TB_DIR = 1'b1;
  localparam int unsigned AW     = 6;

  localparam logic [31:0] M_CTRL = 32'h06F8_3E5F;
  localparam logic [31:0] M_EVT  = 32'h00F8_3E5E;

  localparam logic [AW-1:0] A_ID = 0, A_CTRL = 1, A_CSET = 2, A_CCLR = 3;
  localparam logic [AW-1:0] A_STAT = 16, A_DONE = 18, A_ALIGN = 19;
  localparam logic [AW-1:0] A_IE = 36, A_ISET = 37, A_ICLR = 39;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [31:0]   evt = '0;
  logic          done = 1'b0;
  logic [31:0]   align = '0;
  logic          run, non_incr, poll_wb, irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_ctrl, m_ie, m_stat, m_cnt;

  always #5 clk = ~clk;

  dma_chan_regs #(.DIR(TB_DIR), .ADDR_W(AW), .CNT_W(32)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata),
    .evt_i       (evt),
    .desc_done_i (done),
    .align_i     (align),
    .run_o       (run),
    .non_incr_o  (non_incr),
    .poll_wb_o   (poll_wb),
    .irq_o       (irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    case (a)
      A_ID:                  return {16'h1FC0 + 16'(TB_DIR), 16'h0000};
      A_CTRL, A_CSET, A_CCLR: return m_ctrl;
      A_STAT:                return m_stat;
      A_DONE:                return m_cnt;
      A_ALIGN:               return align;
      A_IE, A_ISET, A_ICLR:  return m_ie;
      default:               return 32'h0;
    endcase
  endfunction

  // one clock cycle, entered and left at a falling edge
  task automatic cycle(bit v, bit w, logic [AW-1:0] a, logic [31:0] d,
                       logic [31:0] e, bit dn, string req);
    logic [31:0] exp_rd, c_new, i_new, s_new, n_new;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    evt = e; done = dn;
    exp_rd = model_read(a);
    c_new = m_ctrl; i_new = m_ie;
    if (v && w) begin
      case (a)
        A_CTRL: c_new = d & M_CTRL;
        A_CSET: c_new = m_ctrl | (d & M_CTRL);
        A_CCLR: c_new = m_ctrl & ~d;
        A_IE:   i_new = d & M_EVT;
        A_ISET: i_new = m_ie | (d & M_EVT);
        A_ICLR: i_new = m_ie & ~d;
        default: ;
      endcase
    end
    s_new = ((v && !w && a == A_STAT) ? 32'h0 : m_stat) | (e & M_EVT & m_ctrl);
    if (c_new[0] && !m_ctrl[0])  n_new = 32'h0;
    else if (dn && m_ctrl[0])    n_new = m_cnt + 32'h1;
    else                         n_new = m_cnt;
    @(posedge clk);
    m_ctrl = c_new; m_ie = i_new; m_stat = s_new; m_cnt = n_new;
    @(negedge clk);
    check("R12", {31'h0, rsp_valid}, {31'h0, v && !w});
    if (v && !w) check(req, rsp_rdata, exp_rd);
    check("R5", {29'h0, poll_wb, non_incr, run}, {29'h0, m_ctrl[26], m_ctrl[25], m_ctrl[0]});
    check("R8", {31'h0, irq}, {31'h0, |(m_stat & m_ie)});
    req_valid = 1'b0; evt = '0; done = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, string req);
    cycle(1'b1, 1'b0, a, 32'h0, 32'h0, 1'b0, req);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, string req);
    cycle(1'b1, 1'b1, a, d, 32'h0, 1'b0, req);
  endtask

  function automatic string req_of(logic [AW-1:0] a);
    case (a)
      A_ID:                  return "R1";
      A_CTRL:                return "R2";
      A_CSET, A_CCLR:        return "R3";
      A_IE, A_ISET, A_ICLR:  return "R4";
      A_STAT:                return "R7";
      A_DONE:                return "R9";
      A_ALIGN:               return "R10";
      default:               return "R11";
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] addr_list [12];
    m_ctrl = '0; m_ie = '0; m_stat = '0; m_cnt = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13", {29'h0, irq, run, rsp_valid}, 32'h0);
    check("R12", {31'h0, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_ID, "R1");
    rd(A_CTRL, "R13");
    rd(A_STAT, "R13");
    rd(A_DONE, "R13");
    // R2: reserved bits drop
    wr(A_CTRL, 32'hFFFF_FFFF, "R2");
    rd(A_CTRL, "R2");
    // R3: aliases
    wr(A_CCLR, 32'h0600_0001, "R3");
    rd(A_CTRL, "R3");
    rd(A_CSET, "R3");
    wr(A_CSET, 32'h0000_0001, "R3");
    rd(A_CCLR, "R3");
    // R4
    wr(A_IE, 32'hFFFF_FFFF, "R4");
    rd(A_IE, "R4");
    wr(A_ICLR, 32'h00F8_0000, "R4");
    wr(A_ISET, 32'h0008_0000, "R4");
    rd(A_ISET, "R4");
    // R6: disabled event and non-event bit ignored
    wr(A_CCLR, 32'h0000_0004, "R6");
    cycle(1'b0, 1'b0, A_ID, 0, 32'h8000_0004, 1'b0, "R6");
    rd(A_STAT, "R6");
    cycle(1'b0, 1'b0, A_ID, 0, 32'h0000_0008, 1'b0, "R8");
    cycle(1'b0, 1'b0, A_ID, 0, 32'h0000_0000, 1'b0, "R8");
    // R7: event during read-clear survives
    cycle(1'b1, 1'b0, A_STAT, 0, 32'h0000_0002, 1'b0, "R7");
    rd(A_STAT, "R7");
    rd(A_STAT, "R7");
    // R9: count while running, frozen when stopped, cleared on restart
    repeat (5) cycle(1'b0, 1'b0, A_ID, 0, 0, 1'b1, "R9");
    rd(A_DONE, "R9");
    wr(A_CCLR, 32'h1, "R9");
    repeat (3) cycle(1'b0, 1'b0, A_ID, 0, 0, 1'b1, "R9");
    rd(A_DONE, "R9");
    cycle(1'b1, 1'b1, A_CSET, 32'h1, 0, 1'b1, "R9");
    rd(A_DONE, "R9");
    // R10
    align = 32'hA5C3_0F12;
    rd(A_ALIGN, "R10");
    // R11: undefined and read-only offsets
    rd(6'd17, "R11");
    rd(6'd63, "R11");
    wr(A_ID, 32'hFFFF_FFFF, "R11");
    wr(A_DONE, 32'h1234, "R11");
    wr(6'd4, 32'hFFFF_FFFF, "R11");
    rd(A_ID, "R11");
    rd(A_DONE, "R11");
    rd(A_CTRL, "R11");
    // random mix
    addr_list = '{A_ID, A_CTRL, A_CSET, A_CCLR, A_STAT, A_DONE, A_ALIGN,
                  A_IE, A_ISET, A_ICLR, A_STAT, A_DONE};
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      logic [31:0]   e;
      bit            v, w;
      a = ($urandom % 8 == 0) ? AW'($urandom) : addr_list[$urandom % 12];
      v = ($urandom % 4) != 0;
      w = $urandom % 2;
      e = ($urandom % 3 == 0) ? ($urandom & $urandom) : 32'h0;
      align = $urandom;
      cycle(v, w, a, $urandom & $urandom, e, ($urandom % 3) == 0, req_of(a));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule